// File: doc/BRIEF.md
# Virtual Segment ID Scrambler

This block turns a 19-bit context number and a 64-bit effective address into a virtual segment ID. First it forms a proto-ID by joining the context to the segment-index bits of the address. Then it scrambles the proto-ID: it multiplies it by the fixed 24-bit prime 12538073 and reduces the product modulo 2^n - 1. Here n is the proto-ID width, 37 for 256 MB segments and 25 for 1 TB segments. No divider is used. The reduction adds the high part of the product to the low part (an end-around fold), then applies a single +1 carry correction.

Two rules sit in front of the scramble. In kernel mode the context comes from the top address nibble: regions 0xC to 0xF map onto contexts 0x7fffc to 0x7ffff. A kernel address in a lower region is reported as an error. In either mode, an address whose low 60 bits reach the per-context range limit (2^RANGE_LOG2 bytes) produces segment ID 0.

The block has three pipeline stages (multiply, fold, correct). It accepts one request per cycle with no stalls.

Top module: `vsid_scrambler`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by exactly three clock cycles, and it is 0 after reset. Back-to-back requests each produce a result in successive cycles.
- R2: With `seg1t_i`=0, proto = {ctx, ea[45:28]} (37 bits) and `vsid_o` = proto*12538073 mod (2^37-1).
- R3: With `seg1t_i`=1, proto = {ctx, ea[45:40]} (25 bits), `vsid_o[24:0]` = proto*12538073 mod (2^25-1), and `vsid_o[36:25]` = 0.
- R4: The result is always below 2^n-1. A proto of all ones (its product is a multiple of 2^n-1) yields 0.
- R5: With `kernel_i`=1 and ea[63:62]=2'b11, the context is 0x7fffc + ea[61:60], and `ctx_i` has no effect.
- R6: With `kernel_i`=0, the context is `ctx_i`, and ea[63:60] has no effect on the result.
- R7: When ea[59:0] >= 2^46, `vsid_o` is 0 and `err_o` is 0.
- R8: With `kernel_i`=1 and ea[63:62] != 2'b11, `err_o` is 1 and `vsid_o` is 0.
- R9: While `valid_o` is 0, `vsid_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request valid |
| kernel_i | input | 1 | Derive the context from the address region |
| seg1t_i | input | 1 | 1: 1 TB segment, 0: 256 MB segment |
| ctx_i | input | 19 | User context number |
| ea_i | input | 64 | Effective address |
| valid_o | output | 1 | Result valid, three cycles after request |
| vsid_o | output | 37 | Scrambled segment ID |
| err_o | output | 1 | Kernel request outside regions 0xC to 0xF |

## Verification
Two rules can act on the same request: the kernel context derivation and the range limit. A kernel address in region 0xF with bits above 2^46 set must give 0 without an error. A kernel address in a low region that is also out of range must raise the error and still give 0. The bench sends both cases, and it also sends the all-ones proto in each segment size, where the carry correction is what brings the fold result to 0. Every result is compared with a true `%` modulus that the bench computes, including when four requests follow one another in consecutive cycles.

// File: rtl/vsid_pkg.sv
package vsid_pkg;
  localparam int unsigned CTX_W       = 19;
  localparam int unsigned MUL_W       = 24;
  localparam int unsigned SEG_SH_256M = 28;
  localparam int unsigned SEG_SH_1T   = 40;
  localparam logic [MUL_W-1:0] VSID_MULT     = 24'd12538073;
  localparam logic [CTX_W-1:0] KERN_CTX_BASE = 19'h7fffc;
endpackage

// File: rtl/vsid_mul_stage.sv
module vsid_mul_stage
  import vsid_pkg::*;
#(
  parameter int unsigned RANGE_LOG2 = 46,
  parameter int unsigned N_W        = 37,
  parameter int unsigned N1T_W      = 25,
  parameter int unsigned PROD_W     = 61
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              kernel_i,
  input  logic              seg1t_i,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic [63:0]       ea_i,
  output logic              v_o,
  output logic              seg1t_o,
  output logic              err_o,
  output logic [PROD_W-1:0] prod_o
);
  logic [CTX_W-1:0] ctx_sel;
  logic             kerr, bad;
  logic [N_W-1:0]   proto;
  logic             unused_ea;

  assign unused_ea = ^ea_i[SEG_SH_256M-1:0];
  assign kerr      = kernel_i && (ea_i[63:62] != 2'b11);
  assign bad       = |ea_i[59:RANGE_LOG2];
  assign ctx_sel   = kernel_i ? KERN_CTX_BASE + CTX_W'(ea_i[61:60]) : ctx_i;

  // a zero proto scrambles to zero, so rejected requests need no extra path
  always_comb begin
    if (kerr || bad)  proto = '0;
    else if (seg1t_i) proto = N_W'({ctx_sel, ea_i[RANGE_LOG2-1:SEG_SH_1T]});
    else              proto = {ctx_sel, ea_i[RANGE_LOG2-1:SEG_SH_256M]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o     <= 1'b0;
      seg1t_o <= 1'b0;
      err_o   <= 1'b0;
      prod_o  <= '0;
    end else begin
      v_o     <= valid_i;
      seg1t_o <= seg1t_i;
      err_o   <= valid_i && kerr;
      prod_o  <= PROD_W'(proto) * PROD_W'(VSID_MULT);
    end
  end

  // R3: a 1 TB product never exceeds 25+24 bits
  p_prod_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_o && seg1t_o) |-> (prod_o >> (N1T_W + MUL_W)) == '0);
endmodule

// File: rtl/vsid_fold_stage.sv
module vsid_fold_stage
  import vsid_pkg::*;
#(
  parameter int unsigned N_W    = 37,
  parameter int unsigned N1T_W  = 25,
  parameter int unsigned PROD_W = 61,
  parameter int unsigned X_W    = 38
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              v_i,
  input  logic              seg1t_i,
  input  logic              err_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic              v_o,
  output logic              seg1t_o,
  output logic              err_o,
  output logic [X_W-1:0]    x_o
);
  logic [X_W-1:0] x_d;

  // end-around fold: 2^n == 1 mod (2^n - 1)
  assign x_d = seg1t_i ? X_W'(prod_i >> N1T_W) + X_W'(prod_i[N1T_W-1:0])
                       : X_W'(prod_i >> N_W)   + X_W'(prod_i[N_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o     <= 1'b0;
      seg1t_o <= 1'b0;
      err_o   <= 1'b0;
      x_o     <= '0;
    end else begin
      v_o     <= v_i;
      seg1t_o <= seg1t_i;
      err_o   <= err_i;
      x_o     <= x_d;
    end
  end

  // R2: folded value is below 2^n + 2^24, so one correction suffices
  p_fold_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_o |-> (seg1t_o ? (x_o < X_W'((64'd1 << N1T_W) + (64'd1 << MUL_W)))
                     : (x_o < X_W'((64'd1 << N_W)   + (64'd1 << MUL_W)))));
endmodule

// File: rtl/vsid_fix_stage.sv
module vsid_fix_stage #(
  parameter int unsigned N_W   = 37,
  parameter int unsigned N1T_W = 25,
  parameter int unsigned X_W   = 38
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           v_i,
  input  logic           seg1t_i,
  input  logic           err_i,
  input  logic [X_W-1:0] x_i,
  output logic           v_o,
  output logic           err_o,
  output logic [N_W-1:0] vsid_o
);
  logic [X_W:0]   inc;
  logic           carry;
  logic [X_W-1:0] sum;
  logic [N_W-1:0] res;
  logic           seg_q;
  logic           unused_inc;

  assign inc        = {1'b0, x_i} + 1'b1;
  assign carry      = seg1t_i ? inc[N1T_W] : inc[N_W];
  assign sum        = x_i + X_W'(carry);
  assign res        = seg1t_i ? N_W'(sum[N1T_W-1:0]) : sum[N_W-1:0];
  assign unused_inc = ^inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o    <= 1'b0;
      err_o  <= 1'b0;
      seg_q  <= 1'b0;
      vsid_o <= '0;
    end else begin
      v_o    <= v_i;
      err_o  <= v_i && err_i;
      seg_q  <= seg1t_i;
      vsid_o <= v_i ? res : '0;
    end
  end

  // R4: result never reaches the modulus itself
  p_below_mod_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_o |-> (seg_q ? (vsid_o < N_W'((64'd1 << N1T_W) - 1))
                   : (vsid_o != {N_W{1'b1}})));
  // R3: upper bits clear for 1 TB segments
  p_upper_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_o && seg_q) |-> (vsid_o >> N1T_W) == '0);
  // R8: an error result carries ID 0
  p_err_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> vsid_o == '0);
  // R9: idle outputs are quiet
  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_o |-> (vsid_o == '0 && !err_o));
endmodule

// File: rtl/vsid_scrambler.sv
module vsid_scrambler
  import vsid_pkg::*;
#(
  parameter int unsigned RANGE_LOG2 = 46
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic        kernel_i,
  input  logic        seg1t_i,
  input  logic [18:0] ctx_i,
  input  logic [63:0] ea_i,
  output logic        valid_o,
  output logic [36:0] vsid_o,
  output logic        err_o
);
  localparam int unsigned ESID_W   = RANGE_LOG2 - SEG_SH_256M;
  localparam int unsigned ESID1T_W = RANGE_LOG2 - SEG_SH_1T;
  localparam int unsigned N_W      = CTX_W + ESID_W;
  localparam int unsigned N1T_W    = CTX_W + ESID1T_W;
  localparam int unsigned PROD_W   = N_W + MUL_W;
  localparam int unsigned X_W      = N_W + 1;

  logic              m_v, m_seg, m_err;
  logic [PROD_W-1:0] m_prod;
  logic              f_v, f_seg, f_err;
  logic [X_W-1:0]    f_x;
  logic [N_W-1:0]    vsid_full;

  vsid_mul_stage #(.RANGE_LOG2(RANGE_LOG2), .N_W(N_W), .N1T_W(N1T_W),
                   .PROD_W(PROD_W)) u_mul (
    .clk_i, .rst_ni, .valid_i, .kernel_i, .seg1t_i,
    .ctx_i(ctx_i), .ea_i,
    .v_o(m_v), .seg1t_o(m_seg), .err_o(m_err), .prod_o(m_prod));

  vsid_fold_stage #(.N_W(N_W), .N1T_W(N1T_W), .PROD_W(PROD_W), .X_W(X_W)) u_fold (
    .clk_i, .rst_ni, .v_i(m_v), .seg1t_i(m_seg), .err_i(m_err), .prod_i(m_prod),
    .v_o(f_v), .seg1t_o(f_seg), .err_o(f_err), .x_o(f_x));

  vsid_fix_stage #(.N_W(N_W), .N1T_W(N1T_W), .X_W(X_W)) u_fix (
    .clk_i, .rst_ni, .v_i(f_v), .seg1t_i(f_seg), .err_i(f_err), .x_i(f_x),
    .v_o(valid_o), .err_o(err_o), .vsid_o(vsid_full));

  assign vsid_o = 37'(vsid_full);

  // cycles since reset, saturating, so the latency check never looks before reset
  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) |-> valid_o == $past(valid_i, 3));
endmodule

// File: tb/vsid_scrambler_tb_top.sv
module vsid_scrambler_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0, kernel_i = 1'b0, seg1t_i = 1'b0;
  logic [18:0] ctx_i = '0;
  logic [63:0] ea_i = '0;
  logic        valid_o, err_o;
  logic [36:0] vsid_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vsid_scrambler dut_i (.clk_i(clk), .rst_ni(rst_n), .valid_i, .kernel_i, .seg1t_i,
                        .ctx_i, .ea_i, .valid_o, .vsid_o, .err_o);

  function automatic logic [36:0] ref_vsid(input bit k, input bit s,
      input logic [18:0] ctx, input logic [63:0] ea, output bit err);
    longint unsigned c, proto, md;
    err = 0;
    if (k && ea[63:62] != 2'b11) begin err = 1; return '0; end
    c = k ? (64'h7fffc + 64'(ea[61:60])) : 64'(ctx);
    if (64'(ea[59:0]) >= (64'd1 << 46)) return '0;
    proto = s ? ((c << 6) | 64'(ea[45:40])) : ((c << 18) | 64'(ea[45:28]));
    md = s ? ((64'd1 << 25) - 1) : ((64'd1 << 37) - 1);
    return 37'((proto * 64'd12538073) % md);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input string req, input bit k, input bit s,
                         input logic [18:0] ctx, input logic [63:0] ea);
    bit e;
    logic [36:0] x;
    x = ref_vsid(k, s, ctx, ea, e);
    @(negedge clk);
    valid_i = 1; kernel_i = k; seg1t_i = s; ctx_i = ctx; ea_i = ea;
    @(negedge clk);
    valid_i = 0;
    chk({req, " R1 no early valid"}, 64'(valid_o), 64'd0);
    @(negedge clk);
    @(negedge clk);
    chk({req, " R1 valid at 3"}, 64'(valid_o), 64'd1);
    chk({req, " vsid"}, 64'(vsid_o), 64'(x));
    chk({req, " err"}, 64'(err_o), 64'(e));
    @(negedge clk);
    chk({req, " R9 idle"}, {62'd0, valid_o, err_o}, 64'd0);
    chk({req, " R9 idle vsid"}, 64'(vsid_o), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 reset valid", 64'(valid_o), 64'd0);
    chk("R9 reset vsid", 64'(vsid_o), 64'd0);
    chk("R9 reset err", 64'(err_o), 64'd0);
  endtask

  task automatic t_user_256m;
    run_one("R2 a", 0, 0, 19'h00005, 64'h0000_1234_5670_0000);
    run_one("R2 b", 0, 0, 19'h5a5a5, 64'h0000_3abc_d000_0000);
    run_one("R2 c", 0, 0, 19'h00001, 64'h0000_0000_1000_0000);
  endtask

  task automatic t_user_1t;
    run_one("R3 a", 0, 1, 19'h12345, 64'h0000_2a00_0000_0000);
    run_one("R3 b", 0, 1, 19'h7fff0, 64'h0000_0100_0000_0000);
  endtask

  task automatic t_wrap;
    run_one("R4 all-ones 256M", 0, 0, 19'h7ffff, 64'h0000_3fff_f000_0000);
    chk("R4 all-ones 256M zero", 64'(vsid_o), 64'd0);
    run_one("R4 all-ones 1T", 0, 1, 19'h7ffff, 64'h0000_3f00_0000_0000);
  endtask

  task automatic t_kernel;
    run_one("R5 region C", 1, 0, 19'h01234, 64'hc000_0012_3000_0000);
    run_one("R5 region D", 1, 0, 19'h7ffff, 64'hd000_0012_3000_0000);
    run_one("R5 region F 1T", 1, 1, 19'h00000, 64'hf000_1500_0000_0000);
    run_one("R6 user high nibble", 0, 0, 19'h00042, 64'ha000_1234_5000_0000);
  endtask

  task automatic t_bad_and_err;
    run_one("R7 bit46", 0, 0, 19'h00005, 64'h0000_4000_0000_0000);
    run_one("R7 edge below", 0, 0, 19'h00005, 64'h0000_3fff_ffff_ffff);
    run_one("R7 kernel F out of range", 1, 0, 19'h0, 64'hf800_0000_0000_0000);
    run_one("R8 kernel region 0", 1, 0, 19'h00005, 64'h0000_1234_5000_0000);
    run_one("R8 kernel region 4 bad", 1, 1, 19'h00005, 64'h4fff_0000_0000_0000);
  endtask

  task automatic t_pipelined;
    logic [18:0] cs[4] = '{19'h00011, 19'h22222, 19'h3fff0, 19'h00007};
    logic [63:0] es[4] = '{64'h0000_0101_0000_0000, 64'h0000_2200_0000_0000,
                          64'h0000_3f00_f000_0000, 64'h0000_0000_7000_0000};
    bit          ss[4] = '{0, 1, 0, 1};
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        bit e;
        logic [36:0] x;
        x = ref_vsid(0, ss[i-3], cs[i-3], es[i-3], e);
        chk($sformatf("R1 pipe valid %0d", i-3), 64'(valid_o), 64'd1);
        chk($sformatf("R2 pipe vsid %0d", i-3), 64'(vsid_o), 64'(x));
      end
      if (i < 4) begin
        valid_i = 1; kernel_i = 0; seg1t_i = ss[i]; ctx_i = cs[i]; ea_i = es[i];
      end else valid_i = 0;
    end
    @(negedge clk);
    chk("R1 pipe drained", 64'(valid_o), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_user_256m();
    t_user_1t();
    t_wrap();
    t_kernel();
    t_bad_and_err();
    t_pipelined();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule